// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

This block turns a serial bit stream into an eight-bit parallel word. Each rising clock edge moves the stream one stage deeper into a chain of flip-flops. A bank of transparent holding latches sits between that chain and the parallel bus. While the strobe input is high, the latches pass the chain contents straight through. When the strobe drops, they freeze the word last seen. The parallel outputs are a tri-state bus. They show the latched word while the enable input is high and release the lines to high impedance when it is low.

The deepest stage is also brought out on two serial outputs, so several blocks can be chained into a longer register. One cascade output changes right after the rising edge. The other repeats the same bit half a period later, on the falling edge, which gives the next device hold margin when the clock edges are slow. Neither cascade output is affected by the enable or the strobe. An active-low asynchronous reset clears the chain, the latches and the falling-edge copy.

Top module: `latched_sipo`

## Requirements
- R1: While `rst_n` is low, every stage, every holding latch and both cascade outputs read 0, whatever the clock does.
- R2: On each rising edge of `clk`, stage 1 loads `ser_in` and every stage k (k = 2..8) loads the old value of stage k-1.
- R3: While `strobe` is 1, the holding latches follow the stage contents, with no clock edge needed.
- R4: While `strobe` is 0, the holding latches keep their value and the parallel outputs do not change, even though shifting goes on.
- R5: While `out_en` is 0, all eight `par_out` lines are high impedance. The latched word is kept and shows again when `out_en` returns to 1.
- R6: A change of `out_en` takes effect on `par_out` combinationally, without a clock edge.
- R7: `cas_rise` equals stage 8 and changes only after a rising clock edge. It does not depend on `out_en` or `strobe`.
- R8: `cas_fall` takes the value of stage 8 on each falling clock edge, so it repeats `cas_rise` half a period later.
- R9: `par_out[i]` carries the latch of stage i+1. Bit 0 is nearest the serial input and bit 7 holds the oldest bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; rising edge shifts, falling edge updates `cas_fall` |
| rst_n | input | 1 | Asynchronous active-low clear |
| ser_in | input | 1 | Serial data entering stage 1 |
| strobe | input | 1 | High makes the holding latches transparent |
| out_en | input | 1 | High drives the parallel bus, low releases it |
| par_out | output | 8 | Tri-state parallel bus of latched stage values |
| cas_rise | output | 1 | Stage 8 bit, updated on the rising edge |
| cas_fall | output | 1 | Stage 8 bit, updated on the falling edge |

## Verification
On every rising edge, the assertions check three things: that the serial bit and each stage move one position per clock, that the latches match the chain whenever the strobe is high, and that the falling-edge copy matches the rising-edge cascade bit. Some behaviour only the bench scenarios can show. These are the release of the bus to high impedance (seen through pull-ups on the bench side), the freezing of the word while the strobe is low, the combinational response to the strobe and the enable between edges, and the asynchronous clear in the middle of a run.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    localparam int SIPO_STAGES = 8;
    localparam int SIPO_MIN_STAGES = 2;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int W = sipo_pkg::SIPO_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    output logic [W-1:0] stage_o
);
    typedef struct packed {
        logic [W-1:0] stage;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d       = chain_q;
        chain_d.stage = {chain_q.stage[W-2:0], ser_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign stage_o = chain_q.stage;
endmodule

// File: rtl/sipo_strobe_latch.sv
module sipo_strobe_latch #(
    parameter int W = sipo_pkg::SIPO_STAGES
) (
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic hold;
        always_latch begin
            if (!rst_n)      hold = 1'b0;
            else if (strobe) hold = d_i[g];
        end
        assign q_o[g] = hold;
    end
endmodule

// File: rtl/sipo_bus_drive.sv
module sipo_bus_drive #(
    parameter int W = sipo_pkg::SIPO_STAGES
) (
    input  logic         oe,
    input  logic [W-1:0] d_i,
    output wire  [W-1:0] bus_o
);
    for (genvar g = 0; g < W; g++) begin : g_line
        assign bus_o[g] = oe ? d_i[g] : 1'bz;
    end
endmodule

// File: rtl/sipo_fall_tap.sv
module sipo_fall_tap (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    output logic bit_o
);
    logic tap_d, tap_q;

    always_comb begin
        tap_d = bit_i;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) tap_q <= 1'b0;
        else        tap_q <= tap_d;
    end

    assign bit_o = tap_q;
endmodule

// File: rtl/latched_sipo.sv
module latched_sipo #(
    parameter int W = sipo_pkg::SIPO_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    input  logic         strobe,
    input  logic         out_en,
    output wire  [W-1:0] par_out,
    output logic         cas_rise,
    output logic         cas_fall
);
    localparam int LAST = W - 1;

    logic [W-1:0] stage_w;
    logic [W-1:0] held_w;

    sipo_shift_chain #(.W(W)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .ser_in (ser_in),
        .stage_o(stage_w)
    );

    sipo_strobe_latch #(.W(W)) u_latch (
        .rst_n (rst_n),
        .strobe(strobe),
        .d_i   (stage_w),
        .q_o   (held_w)
    );

    sipo_bus_drive #(.W(W)) u_drive (
        .oe   (out_en),
        .d_i  (held_w),
        .bus_o(par_out)
    );

    assign cas_rise = stage_w[LAST];

    sipo_fall_tap u_fall (
        .clk  (clk),
        .rst_n(rst_n),
        .bit_i(stage_w[LAST]),
        .bit_o(cas_fall)
    );
endmodule

// File: rtl/sipo_assert_chk.sv
module sipo_assert_chk #(
    parameter int W = sipo_pkg::SIPO_STAGES
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ser_in,
    input logic         strobe,
    input logic [W-1:0] stage,
    input logic [W-1:0] latched,
    input logic         cas_rise,
    input logic         cas_fall
);
    logic warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    AST_SERIAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q |-> stage[0] == $past(ser_in)); // R2

    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q |-> stage[W-1:1] == $past(stage[W-2:0])); // R2

    AST_LATCH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> latched == stage); // R3

    AST_FALL_MATCHES_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        cas_fall == cas_rise); // R8
endmodule

bind latched_sipo sipo_assert_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .strobe  (strobe),
    .stage   (stage_w),
    .latched (held_w),
    .cas_rise(cas_rise),
    .cas_fall(cas_fall)
);

// File: tb/test_latched_sipo.sv
module test_latched_sipo;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic strobe = 1'b0;
    logic out_en = 1'b0;
    wire [W-1:0] bus;
    wire cas_rise, cas_fall;

    for (genvar g = 0; g < W; g++) begin : g_pu
        pullup (bus[g]);
    end

    always #10 clk = ~clk;

    latched_sipo #(.W(W)) i_latched_sipo (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe),
        .out_en(out_en), .par_out(bus), .cas_rise(cas_rise), .cas_fall(cas_fall)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bit m_q[$];
    logic [W-1:0] m_lat = '0;
    logic m_fall = 1'b0;

    function automatic logic [W-1:0] q2v();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = m_q[i];
        return v;
    endfunction

    function automatic logic [W-1:0] exp_bus();
        return out_en ? m_lat : {W{1'b1}};
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_q.delete();
        for (int i = 0; i < W; i++) m_q.push_back(1'b0);
        m_lat  = '0;
        m_fall = 1'b0;
    endtask

    task automatic step(logic s, logic stb, logic oe);
        ser_in = s; strobe = stb; out_en = oe;
        #1;
        if (stb) m_lat = q2v();
        chk(oe ? (stb ? "R3" : "R4") : "R5", bus, exp_bus());
        @(posedge clk);
        m_q.push_front(s);
        void'(m_q.pop_back());
        if (stb) m_lat = q2v();
        #5;
        chk(oe ? (stb ? "R2" : "R4") : "R5", bus, exp_bus());
        chk("R7", {{(W-1){1'b0}}, cas_rise}, {{(W-1){1'b0}}, m_q[W-1]});
        chk("R8 pre-fall", {{(W-1){1'b0}}, cas_fall}, {{(W-1){1'b0}}, m_fall});
        @(negedge clk);
        m_fall = m_q[W-1];
        #2;
        chk("R8", {{(W-1){1'b0}}, cas_fall}, {{(W-1){1'b0}}, m_fall});
        #1;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [7:0] pat;
        model_clear();
        @(negedge clk); #3;
        out_en = 1'b1; strobe = 1'b1;
        @(posedge clk); #5;
        // R1: clocked while in reset, all clear
        chk("R1 bus", bus, '0);
        chk("R1 rise", {{(W-1){1'b0}}, cas_rise}, '0);
        chk("R1 fall", {{(W-1){1'b0}}, cas_fall}, '0);
        @(negedge clk); #3;
        rst_n = 1'b1;

        // R9: single one walks to bit 7
        step(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < W - 1; i++) step(1'b0, 1'b1, 1'b1);
        chk("R9 walk", bus, 8'h80);
        chk("R7 walk", {{(W-1){1'b0}}, cas_rise}, 8'h01);

        // R4: shift a pattern with strobe low, bus stays frozen
        pat = 8'hA5;
        for (int i = 0; i < W; i++) step(pat[i], 1'b0, 1'b1);
        chk("R4 frozen", bus, 8'h80);

        // R3: strobe without clock exposes the chain
        strobe = 1'b1; #1;
        m_lat = q2v();
        chk("R3 no clock", bus, {pat[0], pat[1], pat[2], pat[3], pat[4], pat[5], pat[6], pat[7]});
        strobe = 1'b0; #1;

        // R5/R6: enable toggled without clock
        out_en = 1'b0; #1;
        chk("R6 off", bus, 8'hFF);
        chk("R5 released", bus, exp_bus());
        out_en = 1'b1; #1;
        chk("R6 on", bus, m_lat);
        chk("R5 retained", bus, exp_bus());

        // mixed pattern
        lfsr = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[3], lfsr[5] | lfsr[7]);
        end

        // R1: asynchronous clear mid-run
        out_en = 1'b1; strobe = 1'b0;
        for (int i = 0; i < W; i++) step(1'b1, 1'b1, 1'b1);
        rst_n = 1'b0; #1;
        model_clear();
        chk("R1 async bus", bus, '0);
        chk("R1 async rise", {{(W-1){1'b0}}, cas_rise}, '0);
        chk("R1 async fall", {{(W-1){1'b0}}, cas_fall}, '0);
        @(negedge clk); #3;
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1);
        chk("R2 restart", bus, 8'h0F);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule